// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Qualifier

This block decides whether a breakpoint or watchpoint hit should raise a debug exception. It holds a bank of breakpoint entries and a bank of watchpoint entries. Each breakpoint entry has a control word and a value word. Each watchpoint entry has a control word only. A breakpoint entry sees a raw hit when it is enabled and its value word equals the current program counter. A watchpoint entry sees a raw hit when the matching bit of an externally supplied address-hit vector is set and the entry is enabled. Every raw hit is then filtered by three things: the exception level, the security state, and an optional link to a context-aware breakpoint entry that compares the context identifier.

All entries are evaluated in parallel. For each bank, the lowest-numbered entry that qualifies is reported. A registered fire flag, the entry index and a fault status code appear one clock after the inputs are sampled. The entries are loaded through a simple synchronous write port.

Top module: `dbgm_match`

## Requirements
- R1: During reset and after it, with no entry configured and the gate inputs low, `bp_fire`, `wp_fire`, `wp_wnr`, both index outputs and `fault_status` are zero.
- R2: A breakpoint entry fires when its control bit 0 (enable) is set, its value word equals `pc`, and the entry qualifies. The result appears on the outputs at the clock edge after the edge that sampled the inputs.
- R3: Control bits [15:14] select the security filter. Value 0 accepts either state, values 1 and 3 accept only `secure`=0, and value 2 accepts only `secure`=1.
- R4: The privilege filter depends on the level. At level 2 or 3, control bit 13 must be set. At level 1, control bit 1 must be set. At level 0, control bit 2 must be set.
- R5: For watchpoints, `wp_unpriv`=1 makes the privilege filter use level 0 whatever `cur_el` is.
- R6: No fire is reported in any cycle unless both `glob_en` and `dbg_ok` are 1.
- R7: When control bit 20 (link) of an entry is set, the entry qualifies only if the breakpoint entry numbered by its bits [19:16] passes all of these tests:
  - its number lies in [NBP-NCTX, NBP-1];
  - it is enabled;
  - its bits [23:20] equal 3;
  - `cur_el` is at most 1;
  - its value word equals `ctxid`.
- R8: A watchpoint entry fires when its `wp_hit` bit and its control bit 0 are set and the entry qualifies. `wp_wnr` reports the `wp_write` of that access and is zero when no watchpoint fires.
- R9: `fault_status` is 0x222 when `ext_addr`=1 and 0x002 when `ext_addr`=0 in any cycle where a fire is reported, and it is 0 otherwise.
- R10: When several entries of one bank qualify, the index output names the lowest-numbered one. The index is 0 when its bank does not fire.
- R11: A write on the configuration port (`cfg_sel` 0 = breakpoint control, 1 = breakpoint value, 2 = watchpoint control, 3 = no effect) changes matching from the cycle after the write edge, not in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target of the write: 0 breakpoint control, 1 breakpoint value, 2 watchpoint control |
| cfg_idx | input | 4 | Entry number to write |
| cfg_data | input | 32 | Write data |
| pc | input | AW | Current program counter |
| wp_hit | input | NWP | Per-watchpoint address-hit vector |
| wp_write | input | 1 | The access that hit is a write |
| wp_unpriv | input | 1 | The access that hit is an unprivileged load or store |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state, 1 = secure |
| ctxid | input | 32 | Context identifier |
| glob_en | input | 1 | Global debug enable |
| dbg_ok | input | 1 | Debug exceptions currently allowed |
| ext_addr | input | 1 | Extended addressing format selects the long fault code |
| bp_fire | output | 1 | Breakpoint qualified |
| bp_idx | output | log2(NBP) | Lowest qualifying breakpoint entry |
| wp_fire | output | 1 | Watchpoint qualified |
| wp_idx | output | log2(NWP) | Lowest qualifying watchpoint entry |
| wp_wnr | output | 1 | Write flag of the fired watchpoint access |
| fault_status | output | 10 | Fault status code |

## Verification
Every result is due exactly one rising edge after the inputs that cause it are sampled. A configuration write therefore affects matching only at the edge after the one that stores it. The bench keeps a behavioural model of the entry banks. At each edge the model computes its prediction from the current model state and the driven inputs, and only then applies any configuration write. The outputs are compared at the following falling edge, so each prediction is lined up with the single edge that produces it. The directed phases cover each filter value, the link corner cases and the write-then-match timing. A randomized phase follows.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int CTL_W      = 32;
  localparam int FSR_W      = 10;
  localparam int B_EN       = 0;
  localparam int B_PRIV_EL1 = 1;
  localparam int B_PRIV_EL0 = 2;
  localparam int B_HIGH     = 13;
  localparam int B_SEC_LO   = 14;
  localparam int B_LNUM_LO  = 16;
  localparam int B_LINK     = 20;
  localparam int B_TYPE_LO  = 20;
  localparam logic [3:0] TYPE_CTX = 4'd3;
  localparam logic [FSR_W-1:0] FSR_LONG  = 10'h222;
  localparam logic [FSR_W-1:0] FSR_SHORT = 10'h002;

  function automatic logic level_sec_ok(input logic [CTL_W-1:0] ctl,
                                        input logic [1:0] el,
                                        input logic sec);
    logic [1:0] sc;
    logic s_ok;
    logic l_ok;
    sc = ctl[B_SEC_LO +: 2];
    case (sc)
      2'd0:    s_ok = 1'b1;
      2'd2:    s_ok = sec;
      default: s_ok = ~sec;
    endcase
    case (el)
      2'd0:    l_ok = ctl[B_PRIV_EL0];
      2'd1:    l_ok = ctl[B_PRIV_EL1];
      default: l_ok = ctl[B_HIGH];
    endcase
    return s_ok & l_ok;
  endfunction
endpackage

// File: rtl/dbgm_link.sv
module dbgm_link
  import dbgm_pkg::*;
#(
  parameter int NBP  = 4,
  parameter int NCTX = 2,
  parameter int AW   = 32
) (
  input  logic [NBP-1:0][CTL_W-1:0] bp_ctl,
  input  logic [NBP-1:0][AW-1:0]    bp_val,
  input  logic [31:0]               ctxid,
  input  logic [1:0]                cur_el,
  output logic [NBP-1:0]            link_ok
);
  localparam int FIRST_CTX = NBP - NCTX;

  for (genvar j = 0; j < NBP; j++) begin : g_ent
    if (j >= FIRST_CTX) begin : g_ctx
      assign link_ok[j] = bp_ctl[j][B_EN]
                        & (bp_ctl[j][B_TYPE_LO +: 4] == TYPE_CTX)
                        & (cur_el <= 2'd1)
                        & (bp_val[j][31:0] == ctxid);
    end else begin : g_plain
      assign link_ok[j] = 1'b0;
    end
  end
endmodule

// File: rtl/dbgm_qual.sv
module dbgm_qual
  import dbgm_pkg::*;
#(
  parameter int N   = 4,
  parameter int NBP = 4
) (
  input  logic [N-1:0][CTL_W-1:0] ctl,
  input  logic [N-1:0]            raw_hit,
  input  logic [1:0]              el,
  input  logic                    sec,
  input  logic [NBP-1:0]          link_ok,
  output logic [N-1:0]            qual
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic lsel;
    always_comb begin
      lsel = 1'b0;
      for (int j = 0; j < NBP; j++) begin
        if (ctl[i][B_LNUM_LO +: 4] == 4'(j)) lsel = link_ok[j];
      end
    end
    assign qual[i] = raw_hit[i] & ctl[i][B_EN]
                   & level_sec_ok(ctl[i], el, sec)
                   & (~ctl[i][B_LINK] | lsel);
  end
endmodule

// File: rtl/dbgm_prio.sv
module dbgm_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dbgm_match.sv
module dbgm_match
  import dbgm_pkg::*;
#(
  parameter int NBP  = 4,
  parameter int NWP  = 4,
  parameter int NCTX = 2,
  parameter int AW   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [1:0]                      cfg_sel,
  input  logic [3:0]                      cfg_idx,
  input  logic [31:0]                     cfg_data,
  input  logic [AW-1:0]                   pc,
  input  logic [NWP-1:0]                  wp_hit,
  input  logic                            wp_write,
  input  logic                            wp_unpriv,
  input  logic [1:0]                      cur_el,
  input  logic                            secure,
  input  logic [31:0]                     ctxid,
  input  logic                            glob_en,
  input  logic                            dbg_ok,
  input  logic                            ext_addr,
  output logic                            bp_fire,
  output logic [((NBP>1)?$clog2(NBP):1)-1:0] bp_idx,
  output logic                            wp_fire,
  output logic [((NWP>1)?$clog2(NWP):1)-1:0] wp_idx,
  output logic                            wp_wnr,
  output logic [9:0]                      fault_status
);
  localparam int BIW = (NBP > 1) ? $clog2(NBP) : 1;
  localparam int WIW = (NWP > 1) ? $clog2(NWP) : 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  // entry storage
  logic [NBP-1:0][CTL_W-1:0] bctl_q, bctl_d;
  logic [NBP-1:0][AW-1:0]    bval_q, bval_d;
  logic [NWP-1:0][CTL_W-1:0] wctl_q, wctl_d;
  logic                      cfg_en;

  assign cfg_en = cfg_we & (cfg_sel != 2'd3);

  always_comb begin
    bctl_d = bctl_q;
    bval_d = bval_q;
    wctl_d = wctl_q;
    for (int i = 0; i < NBP; i++) begin
      if (cfg_idx == 4'(i) && cfg_sel == 2'd0) bctl_d[i] = cfg_data;
      if (cfg_idx == 4'(i) && cfg_sel == 2'd1) bval_d[i] = AW'(cfg_data);
    end
    for (int i = 0; i < NWP; i++) begin
      if (cfg_idx == 4'(i) && cfg_sel == 2'd2) wctl_d[i] = cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bctl_q <= '0;
      bval_q <= '0;
      wctl_q <= '0;
    end else if (cfg_en) begin
      bctl_q <= bctl_d;
      bval_q <= bval_d;
      wctl_q <= wctl_d;
    end
  end

  // match and qualification
  logic [NBP-1:0] link_ok, b_raw, b_qual;
  logic [NWP-1:0] w_qual;
  logic [1:0]     w_el;

  for (genvar i = 0; i < NBP; i++) begin : g_bcmp
    assign b_raw[i] = (bval_q[i] == pc);
  end

  assign w_el = wp_unpriv ? 2'd0 : cur_el;

  dbgm_link #(.NBP(NBP), .NCTX(NCTX), .AW(AW)) link_i (
    .bp_ctl(bctl_q), .bp_val(bval_q), .ctxid(ctxid), .cur_el(cur_el),
    .link_ok(link_ok)
  );

  dbgm_qual #(.N(NBP), .NBP(NBP)) bq_i (
    .ctl(bctl_q), .raw_hit(b_raw), .el(cur_el), .sec(secure),
    .link_ok(link_ok), .qual(b_qual)
  );

  dbgm_qual #(.N(NWP), .NBP(NBP)) wq_i (
    .ctl(wctl_q), .raw_hit(wp_hit), .el(w_el), .sec(secure),
    .link_ok(link_ok), .qual(w_qual)
  );

  logic           b_any, w_any;
  logic [BIW-1:0] b_sel;
  logic [WIW-1:0] w_sel;

  dbgm_prio #(.N(NBP), .IW(BIW)) bp_i (.req(b_qual), .any(b_any), .idx(b_sel));
  dbgm_prio #(.N(NWP), .IW(WIW)) wp_i (.req(w_qual), .any(w_any), .idx(w_sel));

  // result next-state
  logic           gate;
  logic           bf_d, wf_d, wnr_d;
  logic [BIW-1:0] bi_d;
  logic [WIW-1:0] wi_d;
  logic [9:0]     fs_d;

  always_comb begin
    gate  = glob_en & dbg_ok;
    bf_d  = gate & b_any;
    wf_d  = gate & w_any;
    bi_d  = bf_d ? b_sel : '0;
    wi_d  = wf_d ? w_sel : '0;
    wnr_d = wf_d & wp_write;
    fs_d  = (bf_d | wf_d) ? (ext_addr ? FSR_LONG : FSR_SHORT) : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bp_fire      <= 1'b0;
      bp_idx       <= '0;
      wp_fire      <= 1'b0;
      wp_idx       <= '0;
      wp_wnr       <= 1'b0;
      fault_status <= '0;
    end else begin
      bp_fire      <= bf_d;
      bp_idx       <= bi_d;
      wp_fire      <= wf_d;
      wp_idx       <= wi_d;
      wp_wnr       <= wnr_d;
      fault_status <= fs_d;
    end
  end
endmodule

// File: rtl/dbgm_match_chk.sv
module dbgm_match_chk #(
  parameter int NWP = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NWP-1:0] wp_hit,
  input logic           wp_write,
  input logic           glob_en,
  input logic           dbg_ok,
  input logic           ext_addr,
  input logic           bp_fire,
  input logic           wp_fire,
  input logic           wp_wnr,
  input logic [9:0]     fault_status
);
  // R6: closed gate in one cycle means no fire on the next
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(glob_en && dbg_ok) |=> (!bp_fire && !wp_fire));

  // R8: no address hit, no watchpoint fire
  p_wp_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit == '0) |=> !wp_fire);

  // R8: write flag follows the sampled access
  p_wnr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_fire |-> (wp_wnr == $past(wp_write)));

  // R9: fault code chosen by the addressing format of the sampled cycle
  p_fsr_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_fire || wp_fire) |-> (fault_status == ($past(ext_addr) ? 10'h222 : 10'h002)));

  // R9: quiet cycles carry no fault code
  p_fsr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_fire && !wp_fire) |-> (fault_status == 10'h000));
endmodule

bind dbgm_match dbgm_match_chk #(.NWP(NWP)) chk_i (
  .clk(clk), .rst_n(rst_n), .wp_hit(wp_hit), .wp_write(wp_write),
  .glob_en(glob_en), .dbg_ok(dbg_ok), .ext_addr(ext_addr),
  .bp_fire(bp_fire), .wp_fire(wp_fire), .wp_wnr(wp_wnr),
  .fault_status(fault_status)
);

// File: tb/dbgm_match_tb_top.sv
module dbgm_match_tb_top;
  localparam int NBP = 4, NWP = 4, NCTX = 2, AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           cfg_we;
  logic [1:0]     cfg_sel;
  logic [3:0]     cfg_idx;
  logic [31:0]    cfg_data;
  logic [AW-1:0]  pc;
  logic [NWP-1:0] wp_hit;
  logic           wp_write, wp_unpriv, secure, glob_en, dbg_ok, ext_addr;
  logic [1:0]     cur_el;
  logic [31:0]    ctxid;
  logic           bp_fire, wp_fire, wp_wnr;
  logic [1:0]     bp_idx, wp_idx;
  logic [9:0]     fault_status;

  dbgm_match #(.NBP(NBP), .NWP(NWP), .NCTX(NCTX), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .pc(pc), .wp_hit(wp_hit),
    .wp_write(wp_write), .wp_unpriv(wp_unpriv), .cur_el(cur_el),
    .secure(secure), .ctxid(ctxid), .glob_en(glob_en), .dbg_ok(dbg_ok),
    .ext_addr(ext_addr), .bp_fire(bp_fire), .bp_idx(bp_idx),
    .wp_fire(wp_fire), .wp_idx(wp_idx), .wp_wnr(wp_wnr),
    .fault_status(fault_status)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_bctl [NBP];
  logic [31:0] m_bval [NBP];
  logic [31:0] m_wctl [NWP];

  function automatic bit m_link(int n);
    if (n < NBP - NCTX || n > NBP - 1) return 0;
    if (!m_bctl[n][0]) return 0;
    if (m_bctl[n][23:20] != 4'd3) return 0;
    if (cur_el > 2'd1) return 0;
    return m_bval[n] == ctxid;
  endfunction

  function automatic bit m_pass(logic [31:0] c, int el);
    int sc;
    bit ok;
    sc = c[15:14];
    if (sc == 2) ok = secure;
    else if (sc == 0) ok = 1;
    else ok = !secure;
    if (el >= 2) ok = ok && c[13];
    else if (el == 1) ok = ok && c[1];
    else ok = ok && c[2];
    if (c[20]) ok = ok && m_link(int'(c[19:16]));
    return ok && c[0];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: predict, update model, clock, compare
  task automatic cyc(string tag);
    bit ebf, ewf, ewnr;
    int ebi, ewi, efs;
    bit gate;
    gate = glob_en && dbg_ok;
    ebf = 0; ewf = 0; ebi = 0; ewi = 0;
    for (int i = NBP - 1; i >= 0; i--)
      if (gate && m_bval[i] == pc && m_pass(m_bctl[i], cur_el)) begin
        ebf = 1; ebi = i;
      end
    for (int i = NWP - 1; i >= 0; i--)
      if (gate && wp_hit[i] && m_pass(m_wctl[i], wp_unpriv ? 0 : cur_el)) begin
        ewf = 1; ewi = i;
      end
    ewnr = ewf && wp_write;
    efs = (ebf || ewf) ? (ext_addr ? 'h222 : 'h002) : 0;
    if (cfg_we) begin
      if (cfg_sel == 0 && cfg_idx < NBP) m_bctl[cfg_idx] = cfg_data;
      if (cfg_sel == 1 && cfg_idx < NBP) m_bval[cfg_idx] = cfg_data;
      if (cfg_sel == 2 && cfg_idx < NWP) m_wctl[cfg_idx] = cfg_data;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    chk(tag, "bp_fire", bp_fire, ebf);
    chk(tag, "bp_idx", bp_idx, ebi);
    chk(tag, "wp_fire", wp_fire, ewf);
    chk(tag, "wp_idx", wp_idx, ewi);
    chk(tag, "wp_wnr", wp_wnr, ewnr);
    chk(tag, "fault_status", fault_status, efs);
  endtask

  task automatic wr(int sel, int idx, logic [31:0] d);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = 4'(idx); cfg_data = d;
    cyc("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBP; i++) begin m_bctl[i] = 0; m_bval[i] = 0; end
    for (int i = 0; i < NWP; i++) m_wctl[i] = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_data = 0;
    pc = 32'h44; wp_hit = 0; wp_write = 0; wp_unpriv = 0; cur_el = 1;
    secure = 0; ctxid = 0; glob_en = 0; dbg_ok = 0; ext_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1", "bp_fire", bp_fire, 0);
    chk("R1", "fault_status", fault_status, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cyc("R1");
    glob_en = 1; dbg_ok = 1;

    // R2 basic breakpoint, R9 both fault formats
    wr(0, 0, 32'h0000_2007);
    wr(1, 0, 32'h0000_1000);
    pc = 32'h1000; cyc("R2");
    ext_addr = 1; cyc("R9");
    pc = 32'h1004; cyc("R2");
    ext_addr = 0;

    // R11 value write and match in the same cycle
    pc = 32'h2000;
    wr(1, 0, 32'h0000_2000);
    cyc("R11");
    wr(3, 0, 32'h0000_0000);
    cyc("R11");

    // R4 privilege filter
    wr(0, 0, 32'h0000_0003);
    cur_el = 1; cyc("R4");
    cur_el = 0; cyc("R4");
    wr(0, 0, 32'h0000_0005);
    cyc("R4");
    cur_el = 2; cyc("R4");
    wr(0, 0, 32'h0000_2001);
    cyc("R4");
    cur_el = 3; cyc("R4");

    // R3 security filter
    cur_el = 1;
    for (int s = 0; s < 4; s++) begin
      wr(0, 0, 32'h0000_0007 | (s << 14));
      secure = 0; cyc("R3");
      secure = 1; cyc("R3");
    end
    secure = 0;
    wr(0, 0, 32'h0000_2007);

    // R6 gate
    glob_en = 0; cyc("R6");
    glob_en = 1; dbg_ok = 0; cyc("R6");
    dbg_ok = 1; cyc("R6");

    // R10 lowest index wins
    wr(1, 0, 32'h0000_5555);
    wr(0, 1, 32'h0000_2007); wr(1, 1, 32'h0000_2000);
    wr(0, 2, 32'h0000_2007); wr(1, 2, 32'h0000_2000);
    cyc("R10");

    // R8 watchpoints, R5 unprivileged access
    wr(2, 1, 32'h0000_0005);
    wr(2, 2, 32'h0000_0005);
    pc = 32'h9999; cur_el = 1;
    wp_hit = 4'b0110; wp_write = 1; wp_unpriv = 0; cyc("R5");
    wp_unpriv = 1; cyc("R5");
    wp_hit = 4'b0100; wp_write = 0; cyc("R8");
    wp_hit = 4'b1001; cyc("R8");
    wp_hit = 0; wp_unpriv = 0;

    // R7 linked context match through entry 3
    wr(0, 3, 32'h0030_0001); wr(1, 3, 32'h0000_CAFE);
    wr(0, 0, 32'h0013_2007); wr(1, 0, 32'h0000_1000);
    pc = 32'h1000; ctxid = 32'hCAFE; cur_el = 1; cyc("R7");
    ctxid = 32'hBEEF; cyc("R7");
    ctxid = 32'hCAFE; cur_el = 2; cyc("R7");
    cur_el = 1;
    wr(0, 1, 32'h0030_0001); wr(1, 1, 32'h0000_CAFE);
    wr(0, 0, 32'h0011_2007);
    cyc("R7");
    wr(0, 0, 32'h0013_2007);
    wr(0, 3, 32'h0030_0000);
    cyc("R7");
    wr(0, 3, 32'h0050_0001);
    cyc("R7");
    wr(0, 3, 32'h0030_0001);
    cyc("R7");

    // randomized mix across all rules
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 5) == 0) begin
        cfg_we = 1; cfg_sel = 2'($urandom_range(0, 3));
        cfg_idx = 4'($urandom_range(0, 3));
        cfg_data = (cfg_sel == 1) ? 32'($urandom_range(0, 3))
                                  : ($urandom & 32'h00FF_E007);
      end
      pc = 32'($urandom_range(0, 3));
      ctxid = 32'($urandom_range(0, 3));
      wp_hit = 4'($urandom); wp_write = 1'($urandom);
      wp_unpriv = 1'($urandom); cur_el = 2'($urandom);
      secure = 1'($urandom); ext_addr = 1'($urandom);
      glob_en = ($urandom_range(0, 7) != 0); dbg_ok = ($urandom_range(0, 7) != 0);
      cyc("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule